// File: doc/BRIEF.md
# Power-Up Strap Latch Controller

This block samples two shared frequency-select strap pins once, when an active-low power-good strobe is first seen low after power-on reset. The strobe passes through a two-flop synchronizer on the reference clock. On the first synchronized low, the block latches the two pin levels as a select code and marks the capture as done. After that, the shared pins become reference-clock outputs. Later activity on the strobe or on the straps cannot alter the latched code. Only a new power-on reset clears it.

A test clock mode can be entered after capture. Entry needs two things: a test request, and a latched code that matches a parameterized test code. Once set, the mode stays set until power-on reset. While it is active, the B strap has no effect. The A strap then chooses the output mode through combinational logic, with no clock involved. A low on A selects high-impedance, with all pin enables low. A high on A selects the reference-divided mode.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While reset is asserted and on the cycle after it is released, sel_code=00, captured=0, pin_oe=00, pin_dir=0, test_mode=0 and out_mode=0 (encoding: 0 normal, 1 high-impedance, 2 reference-divided).
- R2: If pgood_n goes low between two rising edges, captured rises at the third rising edge after that. At that same edge, sel_code takes {strap_b, strap_a}, with bit 0 from A and bit 1 from B. At the second edge, captured is still 0.
- R3: While pgood_n stays high, no capture happens, whatever the straps do.
- R4: After capture, later strobe pulses and strap changes leave sel_code and captured unchanged until reset.
- R5: After capture, outside test mode, pin_oe=11, pin_dir=1 and out_mode=0.
- R6: test_mode sets one rising edge after a cycle in which captured=1, test_req=1 and sel_code equals TEST_CODE (default 11).
- R7: test_req has no effect when sel_code differs from TEST_CODE.
- R8: In test mode, strap_a=0 gives out_mode=1 with pin_oe=00, and strap_a=1 gives out_mode=2 with pin_oe=11. The output follows strap_a with no clock edge.
- R9: In test mode, changes on strap_b do not alter out_mode, pin_oe or sel_code.
- R10: test_mode stays set when test_req drops and when the strobe toggles. Only power-on reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| strap_a | input | 1 | Level seen on shared pin A |
| strap_b | input | 1 | Level seen on shared pin B |
| pgood_n | input | 1 | Active-low power-good strobe, asynchronous |
| test_req | input | 1 | Test-mode request |
| sel_code | output | 2 | Latched select code {B, A} |
| captured | output | 1 | Capture has happened |
| pin_oe | output | 2 | Output enables for pins {B, A} |
| pin_dir | output | 1 | 1 when the shared pins act as outputs |
| test_mode | output | 1 | Sticky test-mode flag |
| out_mode | output | 2 | 0 normal, 1 high-impedance, 2 reference-divided |

## Verification
On every cycle, the assertions check four things:
- the captured flag and the latched code never change after capture;
- a capture only follows a synchronized low;
- test mode never exists without a capture and never clears outside reset;
- the pin enables stay low before capture.

The bench scenarios cover the rest:
- the exact latency through the synchronizer;
- the code decode that gates test-mode entry for each of the four strap patterns;
- the absence of capture while the strobe stays high;
- the combinational response of the output mode to strap A between clock edges.

// File: rtl/strap_pkg.sv
package strap_pkg;
    localparam int STRAP_W = 2;
    localparam int SYNC_STAGES = 2;

    typedef logic [STRAP_W-1:0] strap_t;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_HIZ    = 2'd1,
        MODE_REFDIV = 2'd2
    } out_mode_e;

    function automatic logic code_hits(strap_t code, strap_t target);
        return code == target;
    endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= RST_VAL;
                else if (i == 0) chain[i] <= d;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe_n_sync,
    input  strap_t pins,
    output strap_t code,
    output logic   done
);
    strap_t code_q;
    logic   done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            done_q <= 1'b0;
        end else if (!done_q && !strobe_n_sync) begin
            code_q <= pins;
            done_q <= 1'b1;
        end
    end

    assign code = code_q;
    assign done = done_q;

    assert_done_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q);
    assert_code_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        done_q |=> $stable(code_q));
    assert_capture_on_low_R2: assert property (@(posedge clk) disable iff (rst)
        (!done_q && strobe_n_sync) |=> !done_q);
endmodule

// File: rtl/strap_testmode.sv
module strap_testmode
    import strap_pkg::*;
#(
    parameter strap_t TEST_CODE = 2'b11
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      done,
    input  strap_t    code,
    input  logic      req,
    input  logic      sel_a,
    output logic      test_q,
    output out_mode_e mode,
    output strap_t    oe
);
    logic test_r;

    always_ff @(posedge clk) begin
        if (rst) test_r <= 1'b0;
        else if (done && req && code_hits(code, TEST_CODE)) test_r <= 1'b1;
    end

    always_comb begin
        if (!test_r) mode = MODE_RUN;
        else if (sel_a) mode = MODE_REFDIV;
        else mode = MODE_HIZ;
    end

    always_comb begin
        if (!done || mode == MODE_HIZ) oe = '0;
        else oe = '1;
    end

    assign test_q = test_r;

    assert_test_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        test_r |=> test_r);
    assert_test_needs_capture_R6: assert property (@(posedge clk) disable iff (rst)
        test_r |-> done);
    assert_no_oe_before_capture_R1: assert property (@(posedge clk) disable iff (rst)
        !done |-> (oe == '0));
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
    import strap_pkg::*;
#(
    parameter logic [1:0] TEST_CODE = 2'b11
) (
    input  logic       clk,
    input  logic       por,
    input  logic       strap_a,
    input  logic       strap_b,
    input  logic       pgood_n,
    input  logic       test_req,
    output logic [1:0] sel_code,
    output logic       captured,
    output logic [1:0] pin_oe,
    output logic       pin_dir,
    output logic       test_mode,
    output logic [1:0] out_mode
);
    logic      strobe_sync;
    strap_t    code_w;
    logic      done_w;
    out_mode_e mode_w;
    strap_t    oe_w;

    strap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(por), .d(pgood_n), .q(strobe_sync)
    );

    strap_capture u_cap (
        .clk(clk), .rst(por), .strobe_n_sync(strobe_sync),
        .pins({strap_b, strap_a}), .code(code_w), .done(done_w)
    );

    strap_testmode #(.TEST_CODE(TEST_CODE)) u_test (
        .clk(clk), .rst(por), .done(done_w), .code(code_w), .req(test_req),
        .sel_a(strap_a), .test_q(test_mode), .mode(mode_w), .oe(oe_w)
    );

    assign sel_code = code_w;
    assign captured = done_w;
    assign pin_dir  = done_w;
    assign pin_oe   = oe_w;
    assign out_mode = mode_w;
endmodule

// File: tb/tb_strap_latch_ctrl.sv
module tb_strap_latch_ctrl;
    logic clk = 1'b0;
    logic por, strap_a, strap_b, pgood_n, test_req;
    logic [1:0] sel_code, pin_oe, out_mode;
    logic captured, pin_dir, test_mode;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    strap_latch_ctrl dut (
        .clk(clk), .por(por), .strap_a(strap_a), .strap_b(strap_b),
        .pgood_n(pgood_n), .test_req(test_req), .sel_code(sel_code),
        .captured(captured), .pin_oe(pin_oe), .pin_dir(pin_dir),
        .test_mode(test_mode), .out_mode(out_mode)
    );

    // vector: {strap_b, strap_a, expected test_mode after request}
    localparam logic [2:0] VEC [4] = '{3'b000, 3'b010, 3'b100, 3'b111};

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        por = 1; pgood_n = 1; test_req = 0; strap_a = 0; strap_b = 0;
        repeat (2) @(negedge clk);
        por = 0;
        @(negedge clk);
    endtask

    task automatic do_capture(input logic b, input logic a);
        strap_b = b; strap_a = a; pgood_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2", "captured before third edge", int'(captured), 0);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        por = 1; pgood_n = 1; test_req = 0; strap_a = 0; strap_b = 0;
        repeat (2) @(negedge clk);
        chk("R1", "sel_code in reset", int'(sel_code), 0);
        chk("R1", "pin_oe in reset", int'(pin_oe), 0);
        por = 0;
        @(negedge clk);
        chk("R1", "captured", int'(captured), 0);
        chk("R1", "pin_dir", int'(pin_dir), 0);
        chk("R1", "test_mode", int'(test_mode), 0);
        chk("R1", "out_mode", int'(out_mode), 0);

        // table walk: capture each code, request test mode
        for (int i = 0; i < 4; i++) begin
            do_reset();
            do_capture(VEC[i][2], VEC[i][1]);
            chk("R2", "captured", int'(captured), 1);
            chk("R2", "sel_code", int'(sel_code), int'(VEC[i][2:1]));
            chk("R5", "pin_oe", int'(pin_oe), 3);
            chk("R5", "pin_dir", int'(pin_dir), 1);
            chk("R5", "out_mode", int'(out_mode), 0);
            test_req = 1;
            @(negedge clk);
            chk(VEC[i][0] ? "R6" : "R7", "test_mode", int'(test_mode), int'(VEC[i][0]));
            test_req = 0;
        end

        // R3: strobe high, straps wiggle, no capture
        do_reset();
        for (int k = 0; k < 6; k++) begin
            strap_a = k[0]; strap_b = k[1];
            @(negedge clk);
        end
        chk("R3", "captured with strobe high", int'(captured), 0);
        chk("R3", "pin_oe with strobe high", int'(pin_oe), 0);

        // R4: one-shot capture
        do_reset();
        do_capture(1'b0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            pgood_n = k[0]; strap_a = ~k[0]; strap_b = k[1];
            repeat (3) @(negedge clk);
        end
        chk("R4", "sel_code after later activity", int'(sel_code), 1);
        chk("R4", "captured after later activity", int'(captured), 1);

        // R8/R9/R10: test mode behaviour
        do_reset();
        do_capture(1'b1, 1'b1);
        test_req = 1;
        @(negedge clk);
        test_req = 0;
        chk("R6", "test_mode set", int'(test_mode), 1);
        strap_a = 0;
        #1;
        chk("R8", "out_mode hiz without clock", int'(out_mode), 1);
        chk("R8", "pin_oe hiz", int'(pin_oe), 0);
        strap_a = 1;
        #1;
        chk("R8", "out_mode refdiv without clock", int'(out_mode), 2);
        chk("R8", "pin_oe refdiv", int'(pin_oe), 3);
        strap_b = 0;
        @(negedge clk);
        chk("R9", "out_mode after strap_b", int'(out_mode), 2);
        chk("R9", "pin_oe after strap_b", int'(pin_oe), 3);
        chk("R9", "sel_code after strap_b", int'(sel_code), 3);
        pgood_n = 1;
        repeat (3) @(negedge clk);
        pgood_n = 0;
        repeat (3) @(negedge clk);
        chk("R10", "test_mode after strobe toggle", int'(test_mode), 1);
        por = 1;
        @(negedge clk);
        por = 0;
        pgood_n = 1;
        @(negedge clk);
        chk("R10", "test_mode after por", int'(test_mode), 0);
        chk("R10", "out_mode after por", int'(out_mode), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule